// File: doc/BRIEF.md
# Serial Controller Status and Handshake Outputs

This block keeps the status byte of a serial communications controller and drives its active-low handshake and interrupt outputs. The transmitter and receiver report events to it as one-cycle pulses (holding register taken, shifter finished, character received). The CPU path reports its own strobes: command write, status read, transmit holding register write and receive holding register read. From these it derives a transmit-ready flag, a receive-ready flag and one shared flag that covers both "transmitter empty" and "modem input changed". Each flag appears inverted on an open-drain style output.

The modem inputs (data-set-ready, carrier-detect and clear-to-send, all active low) pass through two-flop synchronizers. A change on data-set-ready or carrier-detect is found by comparing the synchronized value with its value one cycle earlier. The command byte is held here. Terminal-ready and request-to-send are driven from it. So is a send permission for the transmitter that honours clear-to-send without cutting a character short.

Top module: `sio_status_hs`

## Requirements
- R1: After reset the command byte and all status flags are zero. `status` reads 0 while the modem pins are high, and `txrdy_n`, `rxrdy_n`, `empty_chg_n`, `dtr_n` and `rts_n` are all 1.
- R2: One cycle after a command write, `dtr_n` is the complement of command bit 1 and `rts_n` is the complement of command bit 5.
- R3: `txrdy_n` is the complement of status bit 0. Status bit 0 is 1 when command bit 0 (transmit enable) is 1 and the transmit holding register is empty. A `thr_wr` fills the register and `tx_taken` empties it.
- R4: `rxrdy_n` is the complement of status bit 1. `rx_done` sets bit 1 only while command bit 2 (receive enable) is 1. `rhr_rd` clears bit 1. Clearing command bit 2 also clears bit 1, and while bit 2 is 0 an `rx_done` leaves it at 0.
- R5: `empty_chg_n` is the complement of status bit 2. A `tx_done` pulse drives it to 0 on the next cycle.
- R6: A change of the synchronized `dsr_n` or `dcd_n` drives `empty_chg_n` to 0 only when command bit 0 or command bit 2 is 1. Otherwise `empty_chg_n` stays at 1.
- R7: A status read releases `empty_chg_n` unless the transmitter-empty condition still holds. The transmitter-empty condition is set by `tx_done` and cleared by `thr_wr`, so a `thr_wr` is then what releases `empty_chg_n`.
- R8: Status bit 7 is the complement of `dsr_n` and bit 6 is the complement of `dcd_n`, each seen after the two-flop synchronizer. Bits 5 down to 3 read 0.
- R9: `tx_send_ok` is 1 when command bit 0 is 1 and either the synchronized `cts_n` is 0 or `tx_busy` is 1. A character already in the shifter therefore completes after clear-to-send drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command byte write strobe |
| wdata | input | 8 | Command byte value |
| sr_rd | input | 1 | Status read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| tx_taken | input | 1 | Transmitter moved holding register into shifter |
| tx_done | input | 1 | Shifter finished with nothing left to send |
| tx_busy | input | 1 | Shifter is sending a character |
| rx_done | input | 1 | Received character placed in holding register |
| rhr_rd | input | 1 | Receive holding register read strobe |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| status | output | 8 | Status byte |
| txrdy_n | output | 1 | Transmit-ready, active low |
| rxrdy_n | output | 1 | Receive-ready, active low |
| empty_chg_n | output | 1 | Transmitter-empty or modem-change, active low |
| dtr_n | output | 1 | Terminal-ready output |
| rts_n | output | 1 | Request-to-send output |
| tx_send_ok | output | 1 | Transmitter may send |

## Verification
All 256 command bytes are written in turn. This separates the bits that reach `dtr_n`, `rts_n` and transmit-ready from the bits that must not. Modem pin toggles are repeated under all four combinations of the two enable bits, which tells the gated change flag apart from an ungated one. Sequences that mix `tx_done`, modem changes, status reads and holding register writes show which event releases the shared output. A clear-to-send drop is tried both while a character is in flight and while none is, which tells a clean finish apart from an abrupt stop.

// File: rtl/sio_status_hs.sv
module sio_status_hs (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  input  logic       sr_rd,
  input  logic       thr_wr,
  input  logic       tx_taken,
  input  logic       tx_done,
  input  logic       tx_busy,
  input  logic       rx_done,
  input  logic       rhr_rd,
  input  logic       dsr_n,
  input  logic       dcd_n,
  input  logic       cts_n,
  output logic [7:0] status,
  output logic       txrdy_n,
  output logic       rxrdy_n,
  output logic       empty_chg_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       tx_send_ok
);
  logic [7:0] cmd_q;
  logic       thr_full, rx_full, txe_q, chg_q;
  logic [1:0] dsr_sy, dcd_sy, cts_sy;
  logic       dsr_prev, dcd_prev;
  logic       modem_chg, chg_set;

  assign modem_chg = (dsr_sy[1] ^ dsr_prev) | (dcd_sy[1] ^ dcd_prev);
  assign chg_set   = modem_chg & (cmd_q[0] | cmd_q[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      thr_full <= 1'b0;
      rx_full  <= 1'b0;
      txe_q    <= 1'b0;
      chg_q    <= 1'b0;
      dsr_sy   <= 2'b11;
      dcd_sy   <= 2'b11;
      cts_sy   <= 2'b11;
      dsr_prev <= 1'b1;
      dcd_prev <= 1'b1;
    end else begin
      if (cmd_wr) cmd_q <= wdata;

      if (thr_wr)        thr_full <= 1'b1;
      else if (tx_taken) thr_full <= 1'b0;

      if (!cmd_q[2])     rx_full <= 1'b0;
      else if (rx_done)  rx_full <= 1'b1;
      else if (rhr_rd)   rx_full <= 1'b0;

      if (tx_done)       txe_q <= 1'b1;
      else if (thr_wr)   txe_q <= 1'b0;

      if (chg_set)       chg_q <= 1'b1;
      else if (sr_rd)    chg_q <= 1'b0;

      dsr_sy   <= {dsr_sy[0], dsr_n};
      dcd_sy   <= {dcd_sy[0], dcd_n};
      cts_sy   <= {cts_sy[0], cts_n};
      dsr_prev <= dsr_sy[1];
      dcd_prev <= dcd_sy[1];
    end
  end

  assign status      = {~dsr_sy[1], ~dcd_sy[1], 3'b000, txe_q | chg_q, rx_full,
                        cmd_q[0] & ~thr_full};
  assign txrdy_n     = ~status[0];
  assign rxrdy_n     = ~status[1];
  assign empty_chg_n = ~status[2];
  assign dtr_n       = ~cmd_q[1];
  assign rts_n       = ~cmd_q[5];
  assign tx_send_ok  = cmd_q[0] & (~cts_sy[1] | tx_busy);
endmodule

// File: rtl/sio_status_hs_chk.sv
module sio_status_hs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wr,
  input logic [7:0] wdata,
  input logic       sr_rd,
  input logic       thr_wr,
  input logic       tx_done,
  input logic       rx_done,
  input logic       rhr_rd,
  input logic       txe_q,
  input logic       chg_set,
  input logic       txrdy_n,
  input logic       rxrdy_n,
  input logic       empty_chg_n,
  input logic       dtr_n,
  input logic       rts_n
);
  assert_dtr_follows_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> (dtr_n != $past(wdata[1])) && (rts_n != $past(wdata[5])));

  assert_thr_load_R3: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> txrdy_n);

  assert_rhr_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rhr_rd && !rx_done) |=> rxrdy_n);

  assert_tx_done_R5: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !empty_chg_n);

  assert_read_release_R7: assert property (@(posedge clk) disable iff (rst)
    (sr_rd && !txe_q && !chg_set && !tx_done) |=> empty_chg_n);
endmodule

bind sio_status_hs sio_status_hs_chk chk_i (.*);

// File: tb/sio_status_hs_tb_top.sv
module sio_status_hs_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst;
  logic [7:0] wdata;
  logic [6:0] stb;
  logic       cmd_wr, sr_rd, thr_wr, tx_taken, tx_done, rx_done, rhr_rd;
  logic       tx_busy, dsr_n, dcd_n, cts_n;
  logic [7:0] status;
  logic       txrdy_n, rxrdy_n, empty_chg_n, dtr_n, rts_n, tx_send_ok;

  localparam logic [6:0] S_CMD = 7'h01, S_SRD = 7'h02, S_THR = 7'h04,
                         S_TAK = 7'h08, S_TXD = 7'h10, S_RXD = 7'h20, S_RHR = 7'h40;
  assign {rhr_rd, rx_done, tx_done, tx_taken, thr_wr, sr_rd, cmd_wr} = stb;

  sio_status_hs dut_i (.*);

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string r, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] m);
    stb = m;
    @(negedge clk);
    stb = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    wdata = v;
    pulse(S_CMD);
  endtask

  initial begin
    rst = 1'b1; stb = '0; wdata = '0; tx_busy = 1'b0;
    dsr_n = 1'b1; dcd_n = 1'b1; cts_n = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 txrdy_n", txrdy_n, 1);
    chk("R1 rxrdy_n", rxrdy_n, 1);
    chk("R1 empty_chg_n", empty_chg_n, 1);
    chk("R1 dtr_n", dtr_n, 1);
    chk("R1 rts_n", rts_n, 1);

    // R2, R3: sweep every command byte
    for (int c = 0; c < 256; c++) begin
      wr_cmd(8'(c));
      chk("R2 dtr_n", dtr_n, ((c >> 1) & 1) ^ 1);
      chk("R2 rts_n", rts_n, ((c >> 5) & 1) ^ 1);
      chk("R3 txrdy_n", txrdy_n, (c & 1) ^ 1);
    end

    // R6, R8: modem change under all enable combinations
    for (int en = 0; en < 4; en++) begin
      int exp_lo;
      wr_cmd(8'((en & 1) | ((en >> 1) << 2)));
      idle(1);
      exp_lo = (en != 0) ? 0 : 1;
      for (int p = 0; p < 2; p++) begin
        for (int lvl = 0; lvl < 2; lvl++) begin
          if (p == 0) dsr_n = 1'(lvl); else dcd_n = 1'(lvl);
          idle(4);
          chk("R6 empty_chg_n on change", empty_chg_n, exp_lo);
          chk("R8 status[7]", status[7], dsr_n ? 0 : 1);
          chk("R8 status[6]", status[6], dcd_n ? 0 : 1);
          chk("R8 status[5:3]", int'(status[5:3]), 0);
          pulse(S_SRD);
          chk("R7 read releases change", empty_chg_n, 1);
        end
      end
    end

    // R5, R7: transmitter-empty persistence
    wr_cmd(8'h05);
    pulse(S_TXD);
    chk("R5 empty_chg_n after tx_done", empty_chg_n, 0);
    chk("R5 status[2]", status[2], 1);
    pulse(S_SRD);
    chk("R7 read keeps empty", empty_chg_n, 0);
    pulse(S_THR);
    chk("R7 thr_wr releases", empty_chg_n, 1);
    chk("R3 txrdy_n after load", txrdy_n, 1);
    pulse(S_TAK);
    chk("R3 txrdy_n after taken", txrdy_n, 0);
    dsr_n = 1'b0;
    idle(4);
    chk("R6 change asserts", empty_chg_n, 0);
    pulse(S_TXD);
    pulse(S_SRD);
    chk("R7 read with empty pending", empty_chg_n, 0);
    pulse(S_THR);
    chk("R7 thr_wr after read", empty_chg_n, 1);
    pulse(S_TAK);
    dsr_n = 1'b1;
    idle(4);
    pulse(S_TXD);
    dsr_n = 1'b0;
    idle(4);
    pulse(S_THR);
    chk("R7 change pending after thr_wr", empty_chg_n, 0);
    pulse(S_SRD);
    chk("R7 read clears change", empty_chg_n, 1);
    dsr_n = 1'b1;
    idle(4);
    pulse(S_SRD);

    // R4 receive ready
    wr_cmd(8'h04);
    chk("R4 rxrdy_n idle", rxrdy_n, 1);
    pulse(S_RXD);
    chk("R4 rxrdy_n after rx_done", rxrdy_n, 0);
    chk("R4 status[1]", status[1], 1);
    pulse(S_RHR);
    chk("R4 rxrdy_n after read", rxrdy_n, 1);
    pulse(S_RXD);
    wr_cmd(8'h00);
    idle(1);
    chk("R4 disable clears", rxrdy_n, 1);
    pulse(S_RXD);
    idle(1);
    chk("R4 rx_done ignored when disabled", rxrdy_n, 1);
    chk("R4 status[1] disabled", status[1], 0);

    // R9 clear-to-send
    wr_cmd(8'h01);
    cts_n = 1'b0;
    idle(3);
    chk("R9 send ok with cts", tx_send_ok, 1);
    tx_busy = 1'b1;
    cts_n = 1'b1;
    idle(3);
    chk("R9 busy finishes", tx_send_ok, 1);
    tx_busy = 1'b0;
    idle(1);
    chk("R9 stop after char", tx_send_ok, 0);
    cts_n = 1'b0;
    wr_cmd(8'h00);
    idle(3);
    chk("R9 disabled", tx_send_ok, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule